// File: doc/BRIEF.md
# Two-Bank Flash Command Interface Controller

This block is the device side of a byte-wide NOR-style flash with two banks. A host reaches it over a strobe bus: an active-low enable for each bank, plus a shared write strobe, output strobe, address and data byte. Command bytes written to a bank move that bank between reading the array and reading its status byte. They can also start a block erase, a byte program or a change to a block's lock bit. Each bank has its own write state machine, status flags, lock bits and storage array, so one bank can serve array reads while the other is busy.

The array is held in an inferred single-port memory for each bank. It comes up erased (all FFh) and is sized by parameters. Erase and program times are cycle counts. While an operation runs, the state machine owns the memory port. An erase walks the block one byte per cycle, writing FFh. A program reads the old byte and then writes back the AND of the old byte and the program byte. A bank can be reset on its own: hold its enable, the write strobe and the output strobe all low for a set number of cycles.

Top module: `fci_ctrl`

## Requirements
- R1: After `rst`, `dout` is 00h, both banks read the array (which starts at FFh in every byte), and writing 50h makes the bank's status byte read 80h. The status byte is laid out as: bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 low programming supply, all other bits 0.
- R2: A write is taken when `we_n` falls while `oe_n` is high and `be_n[b]` is low. A read presents data on `dout` at the second rising edge after `addr`, `oe_n` and `be_n[b]` are sampled low. With no bank enabled, or with `oe_n` high, `dout` is 00h.
- R3: Writing 40h and then a data byte D at address A stores (old AND D) at A. The bank then reads status, and bit 7 reads 0 for PROG_CYCLES cycles.
- R4: Writing 20h and then D0h at any address inside a block sets all BLK_BYTES bytes of that block to FFh and leaves other blocks unchanged. Status bit 7 reads 0 during the ERASE_CYCLES busy cycles.
- R5: If 20h or 60h is followed by any byte other than its confirm byte, status bits 5 and 4 are both set (status B0h) and the array is unchanged.
- R6: With `vpp_low` high at the confirm write, an erase sets bits 5 and 3 (A8h) and a program sets bits 4 and 3 (98h). The array is unchanged in both cases.
- R7: Writing 60h and then 01h locks the addressed block, and 60h then D0h unlocks it. Erasing a locked block sets bit 5 (A0h), programming one sets bit 4 (90h), and neither changes the array.
- R8: Bits 5, 4 and 3 stay set until 50h is written. While any of them is set, an erase or program confirm is refused, leaving both the array and the status unchanged.
- R9: Writing FFh returns a bank to reading the array.
- R10: Holding `be_n[b]`, `we_n` and `oe_n` low for RST_HOLD consecutive cycles resets bank b. It aborts a running operation, returns the bank to array reads and clears its flags. The other bank is unaffected.
- R11: A hold one cycle shorter than RST_HOLD has no effect.
- R12: Writes to a bank while it is busy are ignored. The other bank keeps serving array reads meanwhile.
- R13: A command byte that is not FFh, 50h, 20h, 40h or 60h, written in array or status mode, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_n | input | BANKS | Active-low bank enables |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | AW | Byte address within a bank |
| din | input | 8 | Command or data byte |
| vpp_low | input | 1 | Programming supply is too low |
| dout | output | 8 | Registered read data or status byte |

## Verification
A wrong mode register shows up at the next read, two cycles later. `dout` then carries a status byte where array data was expected, or the reverse, which is why the abort test reads a byte whose erased value differs from the busy status. A flag that is lost or set by mistake shows at the next status read. A wrong state-machine counter shows either as a ready bit that never returns, or as block bytes that keep their programmed value after the erase. A wrong address mux shows as a neighbouring block that changed.

// File: rtl/fci_pkg.sv
`timescale 1ns/1ps
package fci_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [DW-1:0] OP_CLEAR      = 8'h50;
  localparam logic [DW-1:0] OP_ERASE      = 8'h20;
  localparam logic [DW-1:0] OP_PROG       = 8'h40;
  localparam logic [DW-1:0] OP_LOCK       = 8'h60;
  localparam logic [DW-1:0] OP_CONFIRM    = 8'hD0;
  localparam logic [DW-1:0] OP_LOCK_SET   = 8'h01;

  // status byte bit positions
  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;
  localparam int ST_VPP_LOW   = 3;

  typedef enum logic [2:0] {
    M_ARRAY,
    M_STATUS,
    M_ESETUP,
    M_PSETUP,
    M_LSETUP
  } mode_e;
endpackage

// File: rtl/fci_mem.sv
`timescale 1ns/1ps
module fci_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // the array powers up erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // single port, read-first
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/fci_hold_timer.sv
`timescale 1ns/1ps
module fci_hold_timer #(
  parameter int RST_HOLD = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic pulse_o
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= cond_i && (cnt_q == CW'(RST_HOLD - 1));
      if (!cond_i) cnt_q <= '0;
      else if (cnt_q != CW'(RST_HOLD)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R11
  rst_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  // R10
  rst_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(cond_i));
endmodule

// File: rtl/fci_bank.sv
`timescale 1ns/1ps
module fci_bank
  import fci_pkg::*;
#(
  parameter int BLOCKS       = 16,
  parameter int BLK_BYTES    = 16,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 4,
  parameter int AW           = $clog2(BLOCKS) + $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_rst_i,
  input  logic          wr_evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic          vpp_low_i,
  output logic [DW-1:0] rdata_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int DEPTH = BLOCKS * BLK_BYTES;
  localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  mode_e            mode_q;
  logic             busy_q;
  logic             op_erase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] blk_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    pdata_q;
  logic [2:0]       flg_q;      // {erase err, program err, supply low}
  logic [BLOCKS-1:0] lock_q;

  logic [BLK_W-1:0] blk_sel;
  logic             busy_last;
  logic             clr_cmd;
  logic             m_we;
  logic [AW-1:0]    m_addr;
  logic [DW-1:0]    m_wd;
  logic [DW-1:0]    mem_q;
  logic [DW-1:0]    st_byte;
  logic [DW-1:0]    stat_q;
  logic             show_q;

  assign blk_sel = addr_i[AW-1:OFF_W];

  always_comb begin
    if (op_erase_q) busy_last = (cnt_q == CNT_W'(ERASE_CYCLES - 1));
    else            busy_last = (cnt_q == CNT_W'(PROG_CYCLES - 1));
  end

  assign clr_cmd = wr_evt_i && !busy_q && din_i == OP_CLEAR &&
                   (mode_q == M_ARRAY || mode_q == M_STATUS);

  // command decode and write state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_ARRAY;
      busy_q     <= 1'b0;
      op_erase_q <= 1'b0;
      cnt_q      <= '0;
      blk_q      <= '0;
      addr_q     <= '0;
      pdata_q    <= '0;
      flg_q      <= '0;
      lock_q     <= '0;
    end else if (bank_rst_i) begin
      mode_q <= M_ARRAY;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      flg_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (busy_last) busy_q <= 1'b0;
    end else if (wr_evt_i) begin
      case (mode_q)
        M_ESETUP: begin
          mode_q <= M_STATUS;
          if (din_i != OP_CONFIRM) flg_q[2:1] <= 2'b11;
          else if (flg_q == 3'b000) begin
            if (vpp_low_i) flg_q <= 3'b101;
            else if (lock_q[blk_sel]) flg_q[2] <= 1'b1;
            else begin
              busy_q     <= 1'b1;
              op_erase_q <= 1'b1;
              cnt_q      <= '0;
              blk_q      <= blk_sel;
            end
          end
        end
        M_PSETUP: begin
          mode_q <= M_STATUS;
          if (flg_q == 3'b000) begin
            if (vpp_low_i) flg_q <= 3'b011;
            else if (lock_q[blk_sel]) flg_q[1] <= 1'b1;
            else begin
              busy_q     <= 1'b1;
              op_erase_q <= 1'b0;
              cnt_q      <= '0;
              blk_q      <= blk_sel;
              addr_q     <= addr_i;
              pdata_q    <= din_i;
            end
          end
        end
        M_LSETUP: begin
          mode_q <= M_STATUS;
          if (din_i == OP_LOCK_SET) lock_q[blk_sel] <= 1'b1;
          else if (din_i == OP_CONFIRM) lock_q[blk_sel] <= 1'b0;
          else flg_q[2:1] <= 2'b11;
        end
        default: begin
          case (din_i)
            OP_READ_ARRAY: mode_q <= M_ARRAY;
            OP_CLEAR: begin
              flg_q  <= '0;
              mode_q <= M_STATUS;
            end
            OP_ERASE: mode_q <= M_ESETUP;
            OP_PROG:  mode_q <= M_PSETUP;
            OP_LOCK:  mode_q <= M_LSETUP;
            default: ;
          endcase
        end
      endcase
    end
  end

  // memory port: the state machine owns it while busy
  always_comb begin
    if (!busy_q) begin
      m_addr = addr_i;
      m_we   = 1'b0;
      m_wd   = OP_READ_ARRAY;
    end else if (op_erase_q) begin
      m_addr = {blk_q, cnt_q[OFF_W-1:0]};
      m_we   = (cnt_q < CNT_W'(BLK_BYTES));
      m_wd   = 8'hFF;
    end else begin
      m_addr = addr_q;
      m_we   = (cnt_q == CNT_W'(1));
      m_wd   = mem_q & pdata_q;
    end
  end

  fci_mem #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_mem (
    .clk   (clk),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wd),
    .rdata (mem_q)
  );

  always_comb begin
    st_byte               = '0;
    st_byte[ST_READY]     = !busy_q;
    st_byte[ST_ERASE_ERR] = flg_q[2];
    st_byte[ST_PROG_ERR]  = flg_q[1];
    st_byte[ST_VPP_LOW]   = flg_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      show_q <= 1'b0;
      stat_q <= '0;
    end else begin
      show_q <= busy_q || (mode_q != M_ARRAY);
      stat_q <= st_byte;
    end
  end

  assign rdata_o = show_q ? stat_q : mem_q;

  // R12
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && wr_evt_i && !bank_rst_i |=> $stable(mode_q) && $stable(flg_q));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_q != 3'b000) && !clr_cmd && !bank_rst_i |=>
      ((flg_q & $past(flg_q)) == $past(flg_q)));

  // R8
  refused_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(flg_q) == 3'b000));

  // R6
  vpp_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !$past(vpp_low_i));

  // R7
  lock_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !lock_q[blk_q]);

  // R4
  erase_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) && $past(op_erase_q) && !$past(bank_rst_i) |->
      ($past(cnt_q) == CNT_W'(ERASE_CYCLES - 1)));
endmodule

// File: rtl/fci_ctrl.sv
`timescale 1ns/1ps
module fci_ctrl
  import fci_pkg::*;
#(
  parameter int BANKS        = 2,
  parameter int BLOCKS       = 16,
  parameter int BLK_BYTES    = 16,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 4,
  parameter int RST_HOLD     = 20,
  localparam int AW          = $clog2(BLOCKS) + $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BANKS-1:0] be_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             vpp_low,
  output logic [DW-1:0]    dout
);
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic             we_q;
  logic             we_fall;
  logic [DW-1:0]    bank_rd [BANKS];
  logic             rd_hit;
  logic [SEL_W-1:0] rd_idx;
  logic             rd_q;
  logic [SEL_W-1:0] sel_q;

  assign we_fall = we_q && !we_n;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hold_c;
    logic bank_rst;
    logic wr_evt;

    assign hold_c = !be_n[b] && !we_n && !oe_n;
    assign wr_evt = we_fall && oe_n && !be_n[b];

    fci_hold_timer #(.RST_HOLD(RST_HOLD)) i_hold (
      .clk     (clk),
      .rst     (rst),
      .cond_i  (hold_c),
      .pulse_o (bank_rst)
    );

    fci_bank #(
      .BLOCKS       (BLOCKS),
      .BLK_BYTES    (BLK_BYTES),
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES),
      .AW           (AW)
    ) i_bank (
      .clk        (clk),
      .rst        (rst),
      .bank_rst_i (bank_rst),
      .wr_evt_i   (wr_evt),
      .addr_i     (addr),
      .din_i      (din),
      .vpp_low_i  (vpp_low),
      .rdata_o    (bank_rd[b])
    );
  end

  // lowest enabled bank wins a read
  always_comb begin
    rd_hit = 1'b0;
    rd_idx = '0;
    for (int b = BANKS - 1; b >= 0; b--) begin
      if (!be_n[b]) begin
        rd_hit = !oe_n;
        rd_idx = SEL_W'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      sel_q <= '0;
      dout  <= '0;
    end else begin
      rd_q  <= rd_hit;
      sel_q <= rd_idx;
      dout  <= rd_q ? bank_rd[sel_q] : '0;
    end
  end
endmodule

// File: tb/test_fci_ctrl.sv
`timescale 1ns/1ps
module test_fci_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] be_n = 2'b11;
  logic       we_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] din = 8'h00;
  logic       vpp_low = 1'b0;
  logic [7:0] dout;

  int errs = 0;
  int checks = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  exp;
    string       tag;
    int unsigned due;
  } item_t;
  item_t sbq[$];

  fci_ctrl i_fci_ctrl (
    .clk(clk), .rst(rst), .be_n(be_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .vpp_low(vpp_low), .dout(dout)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      chk(dout === it.exp, it.tag, dout, it.exp);
    end
  end

  task automatic wr(input int b, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    be_n = 2'b11; be_n[b] = 1'b0; addr = a; din = d; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; be_n = 2'b11;
  endtask

  // driver: presents a read and queues the expected byte
  task automatic rd_chk(input int b, input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    be_n = 2'b11; be_n[b] = 1'b0; addr = a; oe_n = 1'b0;
    it.exp = e; it.tag = tag; it.due = cyc + 2;
    sbq.push_back(it);
    repeat (3) @(negedge clk);
    oe_n = 1'b1; be_n = 2'b11;
  endtask

  task automatic peek(input int b, input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    be_n = 2'b11; be_n[b] = 1'b0; addr = a; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    v = dout;
    @(negedge clk);
    oe_n = 1'b1; be_n = 2'b11;
  endtask

  task automatic wait_ready(input int b, input string tag);
    logic [7:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      peek(b, 8'h00, v);
      if (v[7]) begin ok = 1'b1; break; end
    end
    chk(ok, tag, v, 8'h80);
  endtask

  task automatic hold(input int b, input int n);
    @(negedge clk);
    be_n = 2'b11; be_n[b] = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    repeat (n) @(negedge clk);
    we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 8'h00, 8'h01);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout === 8'h00, "R1 reset dout", dout, 8'h00);
    rd_chk(0, 8'h05, 8'hFF, "R1 erased array after reset");
    rd_chk(1, 8'hF0, 8'hFF, "R2 bank1 array read");
    repeat (3) @(negedge clk);
    chk(dout === 8'h00, "R2 idle dout", dout, 8'h00);
    wr(0, 8'h00, 8'h50);
    rd_chk(0, 8'h00, 8'h80, "R1 status after clear");

    // program: AND with old value
    wr(0, 8'h23, 8'h40); wr(0, 8'h23, 8'hA5);
    rd_chk(0, 8'h23, 8'h00, "R3 busy during program");
    wait_ready(0, "R3 program ready");
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h23, 8'hA5, "R3 programmed byte R9 array mode");
    wr(0, 8'h23, 8'h40); wr(0, 8'h23, 8'h0F);
    wait_ready(0, "R3 second program ready");
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h23, 8'h05, "R3 bits only cleared");
    rd_chk(0, 8'h24, 8'hFF, "R3 neighbour untouched");
    wr(0, 8'h30, 8'h40); wr(0, 8'h30, 8'h3C);
    wait_ready(0, "R3 program ready block3");

    // erase block 2
    wr(0, 8'h00, 8'h20); wr(0, 8'h2A, 8'hD0);
    rd_chk(0, 8'h00, 8'h00, "R4 busy during erase");
    wait_ready(0, "R4 erase ready");
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h23, 8'hFF, "R4 erased byte");
    rd_chk(0, 8'h2F, 8'hFF, "R4 erased last byte");
    rd_chk(0, 8'h30, 8'h3C, "R4 other block kept");

    // sequence error and sticky flags
    wr(0, 8'h00, 8'h20); wr(0, 8'h30, 8'h55);
    rd_chk(0, 8'h00, 8'hB0, "R5 sequence error");
    wr(0, 8'h30, 8'h40); wr(0, 8'h30, 8'h00);
    rd_chk(0, 8'h00, 8'hB0, "R8 refused while flagged");
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h30, 8'h3C, "R8 R5 array unchanged");
    wr(0, 8'h00, 8'h50);
    rd_chk(0, 8'h00, 8'h80, "R8 clear status");

    // low supply
    vpp_low = 1'b1;
    wr(0, 8'h00, 8'h20); wr(0, 8'h30, 8'hD0);
    rd_chk(0, 8'h00, 8'hA8, "R6 erase with low supply");
    wr(0, 8'h00, 8'h50);
    wr(0, 8'h30, 8'h40); wr(0, 8'h30, 8'h00);
    rd_chk(0, 8'h00, 8'h98, "R6 program with low supply");
    wr(0, 8'h00, 8'h50);
    vpp_low = 1'b0;
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h30, 8'h3C, "R6 array unchanged");

    // lock bits
    wr(0, 8'h00, 8'h60); wr(0, 8'h31, 8'h01);
    rd_chk(0, 8'h00, 8'h80, "R7 lock accepted");
    wr(0, 8'h00, 8'h20); wr(0, 8'h30, 8'hD0);
    rd_chk(0, 8'h00, 8'hA0, "R7 erase of locked block");
    wr(0, 8'h00, 8'h50);
    wr(0, 8'h3E, 8'h40); wr(0, 8'h3E, 8'h00);
    rd_chk(0, 8'h00, 8'h90, "R7 program of locked block");
    wr(0, 8'h00, 8'h50);
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h30, 8'h3C, "R7 locked data kept");
    rd_chk(0, 8'h3E, 8'hFF, "R7 locked byte kept");
    wr(0, 8'h00, 8'h60); wr(0, 8'h30, 8'hD0);
    wr(0, 8'h30, 8'h40); wr(0, 8'h30, 8'h0F);
    wait_ready(0, "R7 unlocked program ready");
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h30, 8'h0C, "R7 unlocked program");

    // unknown opcodes
    wr(0, 8'h30, 8'h12);
    rd_chk(0, 8'h30, 8'h0C, "R13 unknown in array mode");
    wr(0, 8'h00, 8'h50); wr(0, 8'h00, 8'h12);
    rd_chk(0, 8'h00, 8'h80, "R13 unknown in status mode");

    // busy ignores writes, other bank independent
    wr(0, 8'h00, 8'h20); wr(0, 8'h33, 8'hD0);
    wr(0, 8'h00, 8'hFF);
    rd_chk(0, 8'h00, 8'h00, "R12 write ignored while busy");
    rd_chk(1, 8'h30, 8'hFF, "R12 other bank reads array");
    wait_ready(0, "R12 erase ready");
    rd_chk(0, 8'h00, 8'h80, "R12 still status mode");

    // short hold has no effect
    wr(1, 8'h00, 8'h20); wr(1, 8'h00, 8'h00);
    rd_chk(1, 8'h00, 8'hB0, "R5 bank1 sequence error");
    hold(1, 19);
    rd_chk(1, 8'h00, 8'hB0, "R11 short hold ignored");

    // bank reset
    wr(0, 8'h00, 8'h20); wr(0, 8'h00, 8'h77);
    rd_chk(0, 8'h00, 8'hB0, "R5 bank0 sequence error");
    hold(0, 20);
    rd_chk(0, 8'h30, 8'hFF, "R10 array mode after reset");
    wr(0, 8'h31, 8'h40); wr(0, 8'h31, 8'hFF);
    wait_ready(0, "R10 program after reset");
    rd_chk(0, 8'h00, 8'h80, "R10 flags cleared");
    wr(0, 8'h00, 8'h20); wr(0, 8'h40, 8'hD0);
    hold(0, 20);
    rd_chk(0, 8'h30, 8'hFF, "R10 erase aborted");
    rd_chk(1, 8'h00, 8'hB0, "R10 other bank kept flags");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "scoreboard drained", 8'(sbq.size()), 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule